// File: doc/BRIEF.md
# Windowed Layer Alpha Blender

This block merges one layer pixel with the color that lies under it. The color under it can be the background color or the output of a lower layer. The merge applies only when the current display position lies inside the layer's rectangular window and the layer is switched on. At every other position the color under the layer passes through unchanged.

The blend weight for each side comes from two programmable 3-bit factor codes. Each code chooses either the constant alpha alone or the pixel alpha multiplied by the constant alpha. Each channel of the result is the weighted sum divided by full scale, rounded to the nearest value and saturated to 8 bits.

Pixels enter on a valid/ready stream together with their timing-generator position. Results leave on a second valid/ready stream two register stages later, in the same order. When the output is stalled (`out_valid` high and `out_ready` low), the whole pipeline holds and `in_ready` drops in the same cycle. A pixel is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. The window, enable, alpha and factor settings are sampled together with the pixel they apply to.

Top module: `win_layer_blender`

## Requirements
- R1: After reset is released, `out_valid` is 0. While `out_ready` is 1, `in_ready` is 1.
- R2: A pixel accepted on edge k appears on `out_valid`/`out_rgb` after edge k+1, provided no stall holds the pipeline. Results come out in acceptance order. `in_ready` is 0 exactly while `out_valid` is 1 and `out_ready` is 0. No more than two accepted pixels are ever in flight.
- R3: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_rgb` keep their values on the next cycle.
- R4: A position is inside the window when both of these hold, with every bound inclusive:
  - `cfg_h_first` <= `in_xpos` <= `cfg_h_last`
  - `cfg_v_first` <= `in_ypos` <= `cfg_v_last`

  The bounds are timing-generator coordinates. Screen coordinate s on an axis maps to s + 1 + that axis's accumulated back porch. Outside the window, `out_rgb` equals `in_under_rgb`.
- R5: When `cfg_layer_on` is 0, `out_rgb` equals `in_under_rgb` at every position.
- R6: Inside the window with the layer on, each channel is out = min(255, (L·W1 + U·W2 + 127) / 255), using integer division. L is the layer channel and U is the under channel.
  - Layer pixel fields: alpha [31:24], red [23:16], green [15:8], blue [7:0].
  - `in_under_rgb` and `out_rgb` use the same red/green/blue positions.
- R7: W1 is the product P = (pa·ca + 127) / 255 when `cfg_fac_top` is 6, where pa is the pixel alpha and ca is `cfg_const_alpha`. W1 is ca for code 4 and for every other code.
- R8: W2 is 255 − P when `cfg_fac_base` is 7. W2 is 255 − ca for code 5 and for every other code.
- R9: Factor combinations whose weights sum above 255 saturate each channel at 255.
- R10: With ca = 0xFF, pa = 0xFF and codes 6/7, the output equals the layer color exactly.
- R11: All `cfg_*` inputs are sampled at the pixel's acceptance edge. A change after acceptance does not affect a pixel already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_xpos | input | 12 | Horizontal timing-generator position |
| in_ypos | input | 11 | Vertical timing-generator position |
| in_layer_argb | input | 32 | Layer pixel, alpha/red/green/blue |
| in_under_rgb | input | 24 | Color beneath the layer, red/green/blue |
| cfg_layer_on | input | 1 | Layer enable |
| cfg_h_first | input | 12 | First horizontal window column (inclusive) |
| cfg_h_last | input | 12 | Last horizontal window column (inclusive) |
| cfg_v_first | input | 11 | First vertical window line (inclusive) |
| cfg_v_last | input | 11 | Last vertical window line (inclusive) |
| cfg_const_alpha | input | 8 | Constant alpha, 0xFF means 1.0 |
| cfg_fac_top | input | 3 | Layer-side factor code (6: P, else ca) |
| cfg_fac_base | input | 3 | Under-side factor code (7: 255−P, else 255−ca) |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts output |
| out_rgb | output | 24 | Blended color, red/green/blue |

## Verification
Every result is registered, so a pixel accepted at edge k is due after edge k+1. Each cycle in which the output is stalled adds one cycle to that delay. `in_ready` is combinational on `out_ready` and changes within the same cycle. The bench keeps a two-slot expected pipeline that advances under the same stall rule as R2. It samples `out_valid` and `out_rgb` at the falling edge, before any inputs change. It checks `in_ready` shortly after driving `out_ready`, so each comparison lands in the cycle where the result is due and never straddles an edge.

// File: rtl/win_blend_pkg.sv
package win_blend_pkg;

  // Number of color channels carried through the blender.
  localparam int NCH = 3;

  // Factor codes for the layer-side weight.
  localparam logic [2:0] FAC_TOP_CA   = 3'd4;
  localparam logic [2:0] FAC_TOP_PACA = 3'd6;

  // Factor codes for the under-side weight.
  localparam logic [2:0] FAC_BASE_CA   = 3'd5;
  localparam logic [2:0] FAC_BASE_PACA = 3'd7;

  // Rounded integer division: (num + den/2) / den.
  function automatic logic [31:0] div_round(input logic [31:0] num,
                                            input logic [31:0] den);
    return (num + (den >> 1)) / den;
  endfunction

endpackage

// File: rtl/win_hit_detect.sv
module win_hit_detect #(
  parameter int XW = 12,
  parameter int YW = 11
) (
  input  logic [XW-1:0] xpos,
  input  logic [YW-1:0] ypos,
  input  logic [XW-1:0] h_first,
  input  logic [XW-1:0] h_last,
  input  logic [YW-1:0] v_first,
  input  logic [YW-1:0] v_last,
  output logic          hit
);
  logic in_h;
  logic in_v;

  // Both edges are inclusive on each axis.
  assign in_h = (xpos >= h_first) && (xpos <= h_last);
  assign in_v = (ypos >= v_first) && (ypos <= v_last);
  assign hit  = in_h && in_v;
endmodule

// File: rtl/blend_weight_sel.sv
module blend_weight_sel #(
  parameter int CW = 8
) (
  input  logic [CW-1:0] pix_alpha,
  input  logic [CW-1:0] const_alpha,
  input  logic [2:0]    fac_top,
  input  logic [2:0]    fac_base,
  output logic [CW-1:0] w_top,
  output logic [CW-1:0] w_base
);
  localparam logic [CW-1:0] FULL = '1;

  logic [CW-1:0] prod;

  // Rounded product of the two alphas; full scale times full scale stays full scale.
  assign prod = CW'(win_blend_pkg::div_round(32'(pix_alpha) * 32'(const_alpha),
                                             32'(FULL)));

  always_comb begin
    case (fac_top)
      win_blend_pkg::FAC_TOP_PACA: w_top = prod;
      win_blend_pkg::FAC_TOP_CA:   w_top = const_alpha;
      default:                     w_top = const_alpha;
    endcase

    case (fac_base)
      win_blend_pkg::FAC_BASE_PACA: w_base = FULL - prod;
      win_blend_pkg::FAC_BASE_CA:   w_base = FULL - const_alpha;
      default:                      w_base = FULL - const_alpha;
    endcase
  end
endmodule

// File: rtl/channel_mix.sv
module channel_mix #(
  parameter int CW = 8
) (
  input  logic [CW-1:0] layer_c,
  input  logic [CW-1:0] under_c,
  input  logic [CW-1:0] w_top,
  input  logic [CW-1:0] w_base,
  input  logic          use_layer,
  output logic [CW-1:0] mix_c
);
  localparam logic [CW-1:0] FULL = '1;

  logic [31:0] wsum;
  logic [31:0] quo;

  assign wsum = 32'(layer_c) * 32'(w_top) + 32'(under_c) * 32'(w_base);
  assign quo  = win_blend_pkg::div_round(wsum, 32'(FULL));

  always_comb begin
    if (!use_layer)
      mix_c = under_c;
    else if (quo > 32'(FULL))
      mix_c = FULL;
    else
      mix_c = CW'(quo);
  end
endmodule

// File: rtl/win_layer_blender.sv
module win_layer_blender #(
  parameter int XW = 12,
  parameter int YW = 11,
  parameter int CW = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  logic [XW-1:0]                     in_xpos,
  input  logic [YW-1:0]                     in_ypos,
  input  logic [(win_blend_pkg::NCH+1)*CW-1:0] in_layer_argb,
  input  logic [win_blend_pkg::NCH*CW-1:0]  in_under_rgb,
  input  logic                              cfg_layer_on,
  input  logic [XW-1:0]                     cfg_h_first,
  input  logic [XW-1:0]                     cfg_h_last,
  input  logic [YW-1:0]                     cfg_v_first,
  input  logic [YW-1:0]                     cfg_v_last,
  input  logic [CW-1:0]                     cfg_const_alpha,
  input  logic [2:0]                        cfg_fac_top,
  input  logic [2:0]                        cfg_fac_base,
  output logic                              out_valid,
  input  logic                              out_ready,
  output logic [win_blend_pkg::NCH*CW-1:0]  out_rgb
);
  localparam int NCH  = win_blend_pkg::NCH;
  localparam int RGBW = NCH * CW;
  localparam int PXW  = (NCH + 1) * CW;

  // The whole pipeline moves only when the output register is free or being drained.
  logic adv;
  assign adv      = !(out_valid && !out_ready);
  assign in_ready = adv;

  // Stage 0: window test and weight selection from the configuration at acceptance.
  logic          hit;
  logic [CW-1:0] wt_c;
  logic [CW-1:0] wb_c;

  win_hit_detect #(.XW(XW), .YW(YW)) u_hit (
    .xpos    (in_xpos),
    .ypos    (in_ypos),
    .h_first (cfg_h_first),
    .h_last  (cfg_h_last),
    .v_first (cfg_v_first),
    .v_last  (cfg_v_last),
    .hit     (hit)
  );

  blend_weight_sel #(.CW(CW)) u_wsel (
    .pix_alpha   (in_layer_argb[PXW-1 -: CW]),
    .const_alpha (cfg_const_alpha),
    .fac_top     (cfg_fac_top),
    .fac_base    (cfg_fac_base),
    .w_top       (wt_c),
    .w_base      (wb_c)
  );

  // Stage 1 registers.
  logic            s1_valid;
  logic            s1_use;
  logic [RGBW-1:0] s1_layer;
  logic [RGBW-1:0] s1_under;
  logic [CW-1:0]   s1_wt;
  logic [CW-1:0]   s1_wb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_use   <= 1'b0;
      s1_layer <= '0;
      s1_under <= '0;
      s1_wt    <= '0;
      s1_wb    <= '0;
    end else if (adv) begin
      s1_valid <= in_valid;
      s1_use   <= hit && cfg_layer_on;
      s1_layer <= in_layer_argb[RGBW-1:0];
      s1_under <= in_under_rgb;
      s1_wt    <= wt_c;
      s1_wb    <= wb_c;
    end
  end

  // Stage 2: per-channel weighted sum, rounding and saturation.
  logic [RGBW-1:0] mix_rgb;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    channel_mix #(.CW(CW)) u_mix (
      .layer_c   (s1_layer[c*CW +: CW]),
      .under_c   (s1_under[c*CW +: CW]),
      .w_top     (s1_wt),
      .w_base    (s1_wb),
      .use_layer (s1_use),
      .mix_c     (mix_rgb[c*CW +: CW])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
    end else if (adv) begin
      out_valid <= s1_valid;
      out_rgb   <= mix_rgb;
    end
  end
endmodule

// File: rtl/win_layer_blender_chk.sv
module win_layer_blender_chk #(
  parameter int CW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [3*CW-1:0] in_under_rgb,
  input logic            cfg_layer_on,
  input logic            out_valid,
  input logic            out_ready,
  input logic [3*CW-1:0] out_rgb
);
  // Count of accepted pixels not yet delivered.
  logic [2:0] inflight;
  // Shadow of "layer disabled" and the under color, moved with the stream.
  logic            sh1_pass;
  logic            sh2_pass;
  logic [3*CW-1:0] sh1_under;
  logic [3*CW-1:0] sh2_under;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inflight  <= '0;
      sh1_pass  <= 1'b0;
      sh2_pass  <= 1'b0;
      sh1_under <= '0;
      sh2_under <= '0;
    end else begin
      inflight <= inflight + 3'(in_valid && in_ready) - 3'(out_valid && out_ready);
      if (in_ready) begin
        sh1_pass  <= !cfg_layer_on;
        sh1_under <= in_under_rgb;
        sh2_pass  <= sh1_pass;
        sh2_under <= sh1_under;
      end
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid); // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 3'd2); // R2

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb))); // R3

  AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sh2_pass) |-> (out_rgb == sh2_under)); // R5
endmodule

bind win_layer_blender win_layer_blender_chk #(.CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_under_rgb (in_under_rgb),
  .cfg_layer_on (cfg_layer_on),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_rgb      (out_rgb)
);

// File: tb/tb_win_layer_blender.sv
`timescale 1ns/1ps
module tb_win_layer_blender;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_xpos = '0;
  logic [10:0] in_ypos = '0;
  logic [31:0] in_layer_argb = '0;
  logic [23:0] in_under_rgb = '0;
  logic        cfg_layer_on = 1'b0;
  logic [11:0] cfg_h_first = '0;
  logic [11:0] cfg_h_last = '0;
  logic [10:0] cfg_v_first = '0;
  logic [10:0] cfg_v_last = '0;
  logic [7:0]  cfg_const_alpha = '0;
  logic [2:0]  cfg_fac_top = '0;
  logic [2:0]  cfg_fac_base = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_rgb;

  always #4 clk = ~clk;

  win_layer_blender dut (.*);

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Staged stimulus, copied onto the pins at the falling edge.
  logic        st_valid = 1'b0, st_ready = 1'b1, st_on = 1'b1;
  logic [11:0] st_x = '0, st_hf = '0, st_hl = '0;
  logic [10:0] st_y = '0, st_vf = '0, st_vl = '0;
  logic [31:0] st_layer = '0;
  logic [23:0] st_under = '0;
  logic [7:0]  st_ca = '0;
  logic [2:0]  st_f1 = '0, st_f2 = '0;
  string       st_tag = "R6";

  // Expected two-slot stream model.
  bit          m1_v = 0, m2_v = 0;
  logic [23:0] m1_rgb = '0, m2_rgb = '0;
  string       m1_tag = "R2", m2_tag = "R2";
  bit          prev_stall = 0;
  logic [23:0] prev_rgb = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] ref_px(input logic [31:0] lp, input logic [23:0] up,
      input bit on, input int x, input int y, input int hf, input int hl,
      input int vf, input int vl, input int ca, input int f1c, input int f2c);
    int pa, prod, w1, w2, v;
    logic [23:0] r;
    if (!on || x < hf || x > hl || y < vf || y > vl) return up;
    pa   = int'(lp[31:24]);
    prod = (pa * ca + 127) / 255;
    w1   = (f1c == 6) ? prod : ca;
    w2   = (f2c == 7) ? 255 - prod : 255 - ca;
    for (int c = 0; c < 3; c++) begin
      v = (int'(lp[c*8 +: 8]) * w1 + int'(up[c*8 +: 8]) * w2 + 127) / 255;
      if (v > 255) v = 255;
      r[c*8 +: 8] = 8'(v);
    end
    return r;
  endfunction

  task automatic step();
    bit stall_now;
    @(negedge clk);
    chk(out_valid === m2_v, "R2", "out_valid", 32'(out_valid), 32'(m2_v));
    if (m2_v) chk(out_rgb === m2_rgb, m2_tag, "out_rgb", 32'(out_rgb), 32'(m2_rgb));
    if (prev_stall) chk(out_rgb === prev_rgb && out_valid === 1'b1, "R3", "held out_rgb",
                        32'(out_rgb), 32'(prev_rgb));
    in_valid = st_valid; out_ready = st_ready;
    in_xpos = st_x; in_ypos = st_y; in_layer_argb = st_layer; in_under_rgb = st_under;
    cfg_layer_on = st_on; cfg_h_first = st_hf; cfg_h_last = st_hl;
    cfg_v_first = st_vf; cfg_v_last = st_vl; cfg_const_alpha = st_ca;
    cfg_fac_top = st_f1; cfg_fac_base = st_f2;
    #1;
    chk(in_ready === !(m2_v && !out_ready), "R2", "in_ready", 32'(in_ready),
        32'(!(m2_v && !out_ready)));
    stall_now = m2_v && !out_ready;
    prev_rgb = out_rgb;
    @(posedge clk);
    if (!stall_now) begin
      m2_v = m1_v; m2_rgb = m1_rgb; m2_tag = m1_tag;
      m1_v = in_valid;
      m1_rgb = ref_px(in_layer_argb, in_under_rgb, cfg_layer_on, int'(in_xpos),
                      int'(in_ypos), int'(cfg_h_first), int'(cfg_h_last),
                      int'(cfg_v_first), int'(cfg_v_last), int'(cfg_const_alpha),
                      int'(cfg_fac_top), int'(cfg_fac_base));
      m1_tag = st_tag;
    end
    prev_stall = stall_now;
  endtask

  task automatic send(input int x, input int y, input logic [31:0] lp,
                      input logic [23:0] up, input string tag);
    st_valid = 1'b1; st_x = 12'(x); st_y = 11'(y); st_layer = lp; st_under = up;
    st_tag = tag;
    step();
  endtask

  task automatic idle(input int n);
    st_valid = 1'b0; st_ready = 1'b1;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic base_cfg();
    st_on = 1'b1; st_hf = 12'd10; st_hl = 12'd20; st_vf = 11'd5; st_vl = 11'd8;
    st_ca = 8'hFF; st_f1 = 3'd6; st_f2 = 3'd7; st_ready = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: idle after reset, ready while downstream ready
    chk(out_valid === 1'b0, "R1", "out_valid after reset", 32'(out_valid), 0);
    chk(in_ready === 1'b1, "R1", "in_ready after reset", 32'(in_ready), 1);

    base_cfg();
    // R4: inclusive window edges (layer opaque, so inside shows layer color)
    send(9, 6, 32'hFF112233, 24'hAABBCC, "R4");
    send(10, 6, 32'hFF112233, 24'hAABBCC, "R4");
    send(20, 6, 32'hFF112233, 24'hAABBCC, "R4");
    send(21, 6, 32'hFF112233, 24'hAABBCC, "R4");
    send(15, 4, 32'hFF112233, 24'hAABBCC, "R4");
    send(15, 5, 32'hFF112233, 24'hAABBCC, "R4");
    send(15, 8, 32'hFF112233, 24'hAABBCC, "R4");
    send(15, 9, 32'hFF112233, 24'hAABBCC, "R4");
    // R10: full opacity gives the layer color exactly
    send(12, 6, 32'hFF00FF80, 24'h123456, "R10");
    send(13, 7, 32'hFFFFFFFF, 24'h000000, "R10");
    // R5: layer disabled inside the window
    st_on = 1'b0;
    send(15, 6, 32'hFF445566, 24'h0A0B0C, "R5");
    send(10, 5, 32'h80FFFFFF, 24'hC0FFEE, "R5");
    st_on = 1'b1;
    // R6: random pixels and constant alpha, codes 6/7
    for (int i = 0; i < 20; i++) begin
      st_ca = 8'($urandom_range(0, 255));
      send(int'($urandom_range(10, 20)), int'($urandom_range(5, 8)), $urandom,
           24'($urandom), "R6");
    end
    // R7: every layer-side code with under-side code 5
    for (int f = 0; f < 8; f++) begin
      st_f1 = 3'(f); st_f2 = 3'd5; st_ca = 8'($urandom_range(0, 255));
      send(14, 6, $urandom, 24'($urandom), "R7");
    end
    // R8: every under-side code with layer-side code 4
    for (int f = 0; f < 8; f++) begin
      st_f1 = 3'd4; st_f2 = 3'(f); st_ca = 8'($urandom_range(0, 255));
      send(14, 7, $urandom, 24'($urandom), "R8");
    end
    // R9: weights summing above full scale saturate
    st_f1 = 3'd4; st_f2 = 3'd7; st_ca = 8'd200;
    send(11, 6, 32'h00FFFFFF, 24'hFFFFFF, "R9");
    send(11, 6, 32'h00FF80FF, 24'hFF80C0, "R9");
    idle(3);
    // R3: random back-pressure during a stream
    base_cfg();
    for (int i = 0; i < 80; i++) begin
      st_ready = 1'($urandom_range(0, 1));
      st_valid = 1'($urandom_range(0, 3) != 0);
      st_ca = 8'($urandom);
      st_x = 12'($urandom_range(8, 22)); st_y = 11'($urandom_range(4, 9));
      st_layer = $urandom; st_under = 24'($urandom); st_tag = "R3";
      step();
    end
    idle(3);
    // R11: configuration changes every cycle while pixels stall in flight
    for (int i = 0; i < 60; i++) begin
      st_ready = 1'($urandom_range(0, 1));
      st_valid = 1'b1;
      st_on = 1'($urandom_range(0, 3) != 0);
      st_f1 = 3'($urandom); st_f2 = 3'($urandom); st_ca = 8'($urandom);
      st_hf = 12'($urandom_range(5, 12)); st_hl = 12'($urandom_range(12, 20));
      st_vf = 11'($urandom_range(2, 6)); st_vl = 11'($urandom_range(6, 9));
      st_x = 12'($urandom_range(4, 21)); st_y = 11'($urandom_range(1, 10));
      st_layer = $urandom; st_under = 24'($urandom); st_tag = "R11";
      step();
    end
    idle(4);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule